// File: doc/BRIEF.md
# Indirect Memory Access Port

This block gives a host a small register window into two device-internal spaces that are not mapped directly: a word-wide SRAM and a bank of peripheral registers. The host first loads an address register. It then reads or writes a data register as many times as it needs. Each data access completes one transfer at the address currently held.

On the memory side, separate read and write pointers hold full 32-bit word addresses. Each pointer steps forward by one word after every data access that uses it. On the peripheral side, the address word holds a register offset and a byte count. A write touches only the low bytes that the count covers. A read returns only those bytes. The peripheral address does not advance.

The host port is a simple synchronous register port with one access per cycle. Read data comes back one cycle after the request, together with a valid strobe.

Top module: `indirect_access_port`

## Requirements
- R1: While `rst` is high and after it falls, `reg_rvalid` is 0, both memory pointers and both peripheral address registers read back as 0, and every peripheral register holds 0. SRAM contents are not reset.
- R2: `reg_addr` is a word index. 0 is the memory read address, 1 the memory write address, 2 memory write data, 3 memory read data, 4 the peripheral read address, 5 the peripheral write address, 6 peripheral write data and 7 peripheral read data. Writing 0, 1, 4 or 5 loads that address register. Reading one of them returns its current value. A peripheral address reads back with bits 31:26 and 23:16 as zero.
- R3: A write to index 2 stores `reg_wdata` at the SRAM word addressed by the write pointer. The write pointer then increases by 1.
- R4: A read of index 3 returns the SRAM word at the read pointer. The read pointer then increases by 1. Back-to-back reads return consecutive words.
- R5: Memory data reads never move the write pointer, and memory data writes never move the read pointer. Interleaved accesses therefore each continue from their own address.
- R6: Pointers count over all 32 bits. The SRAM word used is the low `MEM_AW` bits of the pointer, so the SRAM wraps while the pointer keeps counting.
- R7: In a peripheral address word, bits 15:0 give the register offset and bits 25:24 give the byte count minus one. A write to index 6 updates bytes 0 through that count of the register at the write offset. The remaining bytes keep their value.
- R8: A read of index 7 returns the register at the read offset. Bytes above the read byte count are returned as zero.
- R9: Peripheral addresses do not auto-increment. An offset of `PRPH_REGS` or more selects no register: writes there change nothing and reads return 0.
- R10: If `reg_wr` and `reg_rd` are both high in the same cycle, the write takes effect and the read is dropped, so no `reg_rvalid` follows. A read of a write-data index (2 or 6) returns 0 with `reg_rvalid`.
- R11: `reg_rvalid` is high in exactly the cycle after an accepted read, and `reg_rdata` carries that read's result in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Host register write strobe |
| reg_rd | input | 1 | Host register read strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Read result, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read result strobe, one cycle after the read |

## Verification
The hardest situation to reach is one where the SRAM wraps while the 32-bit pointer keeps counting. The bench gets there by loading the write pointer just below a multiple of the SRAM depth, with nonzero upper bits. It then writes across the boundary, reads the pointer back, and reads the wrapped word from index zero. Two other checks need exact alternation of accesses: independent pointers under interleaving, and a read dropped in favour of a write in the same cycle. The bench drives those cycle by cycle, and its scoreboard flags any unexpected valid strobe.

// File: rtl/iap_pkg.sv
package iap_pkg;

    localparam int DW      = 32;
    localparam int HOST_AW = 3;

    typedef enum logic [HOST_AW-1:0] {
        SEL_MEM_RADDR  = 3'd0,
        SEL_MEM_WADDR  = 3'd1,
        SEL_MEM_WDATA  = 3'd2,
        SEL_MEM_RDATA  = 3'd3,
        SEL_PRPH_RADDR = 3'd4,
        SEL_PRPH_WADDR = 3'd5,
        SEL_PRPH_WDATA = 3'd6,
        SEL_PRPH_RDATA = 3'd7
    } win_sel_e;

    // peripheral address word layout
    typedef struct packed {
        logic [5:0]  rsv_hi;
        logic [1:0]  size_m1;
        logic [7:0]  rsv_mid;
        logic [15:0] offset;
    } prph_addr_t;

    // decoded host strobes for one window
    typedef struct packed {
        logic ld_raddr;
        logic ld_waddr;
        logic wr_data;
        logic rd_data;
    } win_ctl_t;

    function automatic prph_addr_t prph_addr_load(logic [DW-1:0] w);
        prph_addr_t a;
        a         = '0;
        a.size_m1 = w[25:24];
        a.offset  = w[15:0];
        return a;
    endfunction

    function automatic logic [3:0] lane_enables(logic [1:0] size_m1);
        logic [3:0] be;
        case (size_m1)
            2'd0:    be = 4'b0001;
            2'd1:    be = 4'b0011;
            2'd2:    be = 4'b0111;
            default: be = 4'b1111;
        endcase
        return be;
    endfunction

    function automatic logic [DW-1:0] lane_mask(logic [3:0] be);
        logic [DW-1:0] m;
        for (int b = 0; b < 4; b++) m[8*b +: 8] = {8{be[b]}};
        return m;
    endfunction

endpackage

// File: rtl/iap_mem_win.sv
module iap_mem_win
    import iap_pkg::*;
#(
    parameter int MEM_AW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  win_ctl_t      ctl,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rptr,
    output logic [DW-1:0] wptr,
    output logic [DW-1:0] rdata
);
    localparam int MEM_WORDS = 1 << MEM_AW;

    logic [DW-1:0] mem_q [MEM_WORDS];
    logic [DW-1:0] rptr_q, wptr_q, rdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rptr_q <= '0;
            wptr_q <= '0;
        end else begin
            if (ctl.ld_raddr)     rptr_q <= wdata;
            else if (ctl.rd_data) rptr_q <= rptr_q + 32'd1;
            if (ctl.ld_waddr)     wptr_q <= wdata;
            else if (ctl.wr_data) wptr_q <= wptr_q + 32'd1;
        end
    end

    always_ff @(posedge clk) begin
        if (ctl.wr_data) mem_q[wptr_q[MEM_AW-1:0]] <= wdata;
        if (ctl.rd_data) rdata_q <= mem_q[rptr_q[MEM_AW-1:0]];
    end

    assign rptr  = rptr_q;
    assign wptr  = wptr_q;
    assign rdata = rdata_q;

    // R5: the read pointer holds unless it is loaded or used
    a_r5_rptr_hold: assert property (@(posedge clk) disable iff (rst)
        !(ctl.ld_raddr || ctl.rd_data) |=> $stable(rptr_q));
    // R5: the write pointer holds unless it is loaded or used
    a_r5_wptr_hold: assert property (@(posedge clk) disable iff (rst)
        !(ctl.ld_waddr || ctl.wr_data) |=> $stable(wptr_q));
    // R3: a data write advances the write pointer by one word
    a_r3_wptr_step: assert property (@(posedge clk) disable iff (rst)
        ctl.wr_data |=> wptr_q == $past(wptr_q) + 32'd1);
    // R4: a data read advances the read pointer by one word
    a_r4_rptr_step: assert property (@(posedge clk) disable iff (rst)
        ctl.rd_data |=> rptr_q == $past(rptr_q) + 32'd1);

endmodule

// File: rtl/iap_prph_win.sv
module iap_prph_win
    import iap_pkg::*;
#(
    parameter int PRPH_REGS = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  win_ctl_t      ctl,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] raddr_word,
    output logic [DW-1:0] waddr_word,
    output logic [DW-1:0] rdata
);
    localparam int BANK_W = PRPH_REGS * DW;

    prph_addr_t      raddr_q, waddr_q;
    logic [3:0]      be_wr, be_rd;
    logic [BANK_W-1:0] bank_flat;
    logic [DW-1:0]   rd_word, rdata_q;
    logic            rd_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            raddr_q <= '0;
            waddr_q <= '0;
        end else begin
            if (ctl.ld_raddr) raddr_q <= prph_addr_load(wdata);
            if (ctl.ld_waddr) waddr_q <= prph_addr_load(wdata);
        end
    end

    assign be_wr = lane_enables(waddr_q.size_m1);
    assign be_rd = lane_enables(raddr_q.size_m1);

    for (genvar r = 0; r < PRPH_REGS; r++) begin : g_reg
        logic hit;
        assign hit = ctl.wr_data && (waddr_q.offset == 16'(r));
        for (genvar b = 0; b < 4; b++) begin : g_lane
            logic [7:0] byte_q;
            always_ff @(posedge clk) begin
                if (rst)                   byte_q <= '0;
                else if (hit && be_wr[b])  byte_q <= wdata[8*b +: 8];
            end
            assign bank_flat[r*DW + 8*b +: 8] = byte_q;
        end
    end

    always_comb begin
        rd_word = '0;
        rd_hit  = 1'b0;
        for (int r = 0; r < PRPH_REGS; r++) begin
            if (raddr_q.offset == 16'(r)) begin
                rd_word = bank_flat[r*DW +: DW];
                rd_hit  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)              rdata_q <= '0;
        else if (ctl.rd_data) rdata_q <= rd_hit ? (rd_word & lane_mask(be_rd)) : '0;
    end

    assign raddr_word = raddr_q;
    assign waddr_word = waddr_q;
    assign rdata      = rdata_q;

    // R9: data accesses never move the peripheral addresses
    a_r9_raddr_fixed: assert property (@(posedge clk) disable iff (rst)
        (ctl.rd_data || ctl.wr_data) |=> $stable(raddr_q) && $stable(waddr_q));
    // R7: a one-byte write to register 0 leaves its upper bytes alone
    a_r7_upper_kept: assert property (@(posedge clk) disable iff (rst)
        (ctl.wr_data && waddr_q.offset == 16'd0 && waddr_q.size_m1 == 2'd0)
        |=> bank_flat[DW-1:8] == $past(bank_flat[DW-1:8]));
    // R8: a one-byte read returns zero above byte 0
    a_r8_read_masked: assert property (@(posedge clk) disable iff (rst)
        (ctl.rd_data && raddr_q.size_m1 == 2'd0) |=> rdata_q[DW-1:8] == '0);

endmodule

// File: rtl/indirect_access_port.sv
module indirect_access_port
    import iap_pkg::*;
#(
    parameter int MEM_AW    = 6,
    parameter int PRPH_REGS = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        reg_rvalid
);
    win_sel_e      sel, sel_q;
    logic          wr_go, rd_go, rvalid_q;
    win_ctl_t      mem_ctl, prph_ctl;
    logic [DW-1:0] mem_rptr, mem_wptr, mem_rdata;
    logic [DW-1:0] p_raddr, p_waddr, p_rdata;
    logic [DW-1:0] direct_q, direct_d;

    assign sel   = win_sel_e'(reg_addr);
    assign wr_go = reg_wr;
    assign rd_go = reg_rd && !reg_wr;

    always_comb begin
        mem_ctl           = '0;
        prph_ctl          = '0;
        mem_ctl.ld_raddr  = wr_go && sel == SEL_MEM_RADDR;
        mem_ctl.ld_waddr  = wr_go && sel == SEL_MEM_WADDR;
        mem_ctl.wr_data   = wr_go && sel == SEL_MEM_WDATA;
        mem_ctl.rd_data   = rd_go && sel == SEL_MEM_RDATA;
        prph_ctl.ld_raddr = wr_go && sel == SEL_PRPH_RADDR;
        prph_ctl.ld_waddr = wr_go && sel == SEL_PRPH_WADDR;
        prph_ctl.wr_data  = wr_go && sel == SEL_PRPH_WDATA;
        prph_ctl.rd_data  = rd_go && sel == SEL_PRPH_RDATA;
    end

    iap_mem_win #(.MEM_AW(MEM_AW)) u_mem (
        .clk   (clk),
        .rst   (rst),
        .ctl   (mem_ctl),
        .wdata (reg_wdata),
        .rptr  (mem_rptr),
        .wptr  (mem_wptr),
        .rdata (mem_rdata)
    );

    iap_prph_win #(.PRPH_REGS(PRPH_REGS)) u_prph (
        .clk        (clk),
        .rst        (rst),
        .ctl        (prph_ctl),
        .wdata      (reg_wdata),
        .raddr_word (p_raddr),
        .waddr_word (p_waddr),
        .rdata      (p_rdata)
    );

    always_comb begin
        case (sel)
            SEL_MEM_RADDR:  direct_d = mem_rptr;
            SEL_MEM_WADDR:  direct_d = mem_wptr;
            SEL_PRPH_RADDR: direct_d = p_raddr;
            SEL_PRPH_WADDR: direct_d = p_waddr;
            default:        direct_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rvalid_q <= 1'b0;
            sel_q    <= SEL_MEM_RADDR;
            direct_q <= '0;
        end else begin
            rvalid_q <= rd_go;
            if (rd_go) begin
                sel_q    <= sel;
                direct_q <= direct_d;
            end
        end
    end

    always_comb begin
        if (!rvalid_q)                    reg_rdata = '0;
        else if (sel_q == SEL_MEM_RDATA)  reg_rdata = mem_rdata;
        else if (sel_q == SEL_PRPH_RDATA) reg_rdata = p_rdata;
        else                              reg_rdata = direct_q;
    end
    assign reg_rvalid = rvalid_q;

    // R11: an accepted read is answered in the next cycle
    a_r11_rvalid_follows: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && !reg_wr) |=> reg_rvalid);
    // R10: no read accepted, so no strobe in the next cycle
    a_r10_no_stray_valid: assert property (@(posedge clk) disable iff (rst)
        !(reg_rd && !reg_wr) |=> !reg_rvalid);

endmodule

// File: tb/indirect_access_port_test.sv
`timescale 1ns/1ps
module indirect_access_port_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_wr, reg_rd;
    logic [2:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        reg_rvalid;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    indirect_access_port uut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid)
    );

    function automatic logic [31:0] pa(logic [15:0] off, logic [1:0] sz);
        return {6'b0, sz, 8'b0, off};
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops one expected item per strobe
    always @(negedge clk) begin
        if (!rst && reg_rvalid) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R11: actual=strobe expected=none data=%h", reg_rdata);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, reg_rdata, e);
            end
        end
    end

    // each task starts and ends at a falling edge
    task automatic hwr(logic [2:0] a, logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic hrd(logic [2:0] a, logic [31:0] exp, string tag);
        reg_rd = 1'b1; reg_addr = a;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    initial begin
        #2_000_000;
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
        repeat (3) @(negedge clk);
        check("R1 rvalid in reset", {31'b0, reg_rvalid}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 rvalid after reset", {31'b0, reg_rvalid}, 32'd0);
        hrd(3'd0, 32'd0, "R1 mem raddr");
        hrd(3'd1, 32'd0, "R1 mem waddr");
        hrd(3'd4, 32'd0, "R1 prph raddr");
        hrd(3'd5, 32'd0, "R1 prph waddr");
        hrd(3'd7, 32'd0, "R1 prph reg0");

        // R2 / R3
        hwr(3'd1, 32'd5);
        hrd(3'd1, 32'd5, "R2 waddr readback");
        for (int i = 0; i < 4; i++) hwr(3'd2, 32'hA000_0000 + i);
        hrd(3'd1, 32'd9, "R3 waddr advanced");
        // R4 back-to-back reads
        hwr(3'd0, 32'd5);
        hrd(3'd0, 32'd5, "R2 raddr readback");
        for (int i = 0; i < 4; i++) hrd(3'd3, 32'hA000_0000 + i, "R4 burst read");
        hrd(3'd0, 32'd9, "R4 raddr advanced");

        // R5 interleaved
        hwr(3'd0, 32'd5);
        hwr(3'd1, 32'd20);
        hrd(3'd3, 32'hA000_0000, "R5 interleave rd0");
        hwr(3'd2, 32'hB000_0000);
        hrd(3'd3, 32'hA000_0001, "R5 interleave rd1");
        hwr(3'd2, 32'hB000_0001);
        hrd(3'd0, 32'd7,  "R5 raddr after mix");
        hrd(3'd1, 32'd22, "R5 waddr after mix");
        hwr(3'd0, 32'd20);
        hrd(3'd3, 32'hB000_0000, "R5 mixed word0");
        hrd(3'd3, 32'hB000_0001, "R5 mixed word1");

        // R6 wrap: pointer 0x13F addresses word 63, 0x140 addresses word 0
        hwr(3'd1, 32'h0000_013F);
        hwr(3'd2, 32'hC000_0000);
        hwr(3'd2, 32'hC000_0001);
        hrd(3'd1, 32'h0000_0141, "R6 pointer keeps counting");
        hwr(3'd0, 32'd0);
        hrd(3'd3, 32'hC000_0001, "R6 wrapped word0");
        hwr(3'd0, 32'd63);
        hrd(3'd3, 32'hC000_0000, "R6 top word");

        // R7 byte-count writes at offset 3
        hwr(3'd5, pa(16'd3, 2'd3));
        hwr(3'd4, pa(16'd3, 2'd3));
        hwr(3'd6, 32'h1122_3344);
        hrd(3'd7, 32'h1122_3344, "R7 full word");
        hwr(3'd5, pa(16'd3, 2'd0));
        hwr(3'd6, 32'hAABB_CCDD);
        hrd(3'd7, 32'h1122_33DD, "R7 one byte");
        hwr(3'd5, pa(16'd3, 2'd1));
        hwr(3'd6, 32'h5566_7788);
        hrd(3'd7, 32'h1122_7788, "R7 two bytes");
        hwr(3'd5, pa(16'd3, 2'd2));
        hwr(3'd6, 32'hFFEE_DDCC);
        hrd(3'd7, 32'h11EE_DDCC, "R7 three bytes");
        // R8 masked reads
        hwr(3'd4, pa(16'd3, 2'd1));
        hrd(3'd7, 32'h0000_DDCC, "R8 two-byte read");
        hwr(3'd4, pa(16'd3, 2'd0));
        hrd(3'd7, 32'h0000_00CC, "R8 one-byte read");
        hwr(3'd4, pa(16'd3, 2'd2));
        hrd(3'd7, 32'h00EE_DDCC, "R8 three-byte read");

        // R9 no auto-increment, out-of-range offset
        hwr(3'd5, pa(16'd5, 2'd3));
        hwr(3'd6, 32'd1);
        hwr(3'd6, 32'd2);
        hrd(3'd5, pa(16'd5, 2'd3), "R9 waddr unchanged");
        hwr(3'd4, pa(16'd5, 2'd3));
        hrd(3'd7, 32'd2, "R9 same register rewritten");
        hrd(3'd7, 32'd2, "R9 raddr unchanged");
        hwr(3'd4, pa(16'd6, 2'd3));
        hrd(3'd7, 32'd0, "R9 next register untouched");
        hwr(3'd5, pa(16'd16, 2'd3));
        hwr(3'd6, 32'hDEAD_BEEF);
        hwr(3'd4, pa(16'd16, 2'd3));
        hrd(3'd7, 32'd0, "R9 out of range read");
        hwr(3'd4, pa(16'd0, 2'd3));
        hrd(3'd7, 32'd0, "R9 reg0 untouched");
        hwr(3'd4, 32'hFC12_0007);
        hrd(3'd4, 32'h0000_0007, "R2 reserved bits dropped");

        // R10 write and read together
        reg_wr = 1'b1; reg_rd = 1'b1; reg_addr = 3'd1; reg_wdata = 32'h30;
        @(negedge clk);
        reg_wr = 1'b0; reg_rd = 1'b0;
        check("R10 read dropped", {31'b0, reg_rvalid}, 32'd0);
        hrd(3'd1, 32'h30, "R10 write took effect");
        hrd(3'd2, 32'd0, "R10 mem wdata reads zero");
        hrd(3'd6, 32'd0, "R10 prph wdata reads zero");

        repeat (3) @(negedge clk);
        check("R11 all reads answered", exp_q.size(), 32'd0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule